// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block keeps the interrupt state of a packet controller. It holds an 8-bit status register and an 8-bit enable mask, and drives one level-sensitive interrupt line that is high while any enabled status bit is set. Some status bits follow the state of the queues around the controller. The transmit-queue-empty bit and the transmit-done bit are set again on every clock while their queue condition holds. The receive bit is recomputed each time the receive queue is popped. The other bits latch one-cycle event pulses and stay set until software clears them.

Software clears bits by writing an acknowledge value. Only the bits in a fixed clearable set respond to this write. When the acknowledge value includes the transmit-done bit and the completion queue holds an entry, the block sends a one-cycle pop request to that queue. It then evaluates the transmit-done bit against the queue length that remains after the pop. The queues and the event sources are outside the block: their lengths and pulses arrive as inputs. The reset input is asynchronous and active low, and the block releases it internally in step with the clock.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status reads 0x04, the mask reads 0x00, and irq and done_pop are low.
- R2: Status bit 0x04 (transmit queue empty) is set on the next clock whenever tx_q_count is zero. It cannot be cleared while that holds. It stays set after the queue fills, until it is acknowledged.
- R3: Status bit 0x02 (transmit done) is set on the next clock whenever done_q_count is non-zero. When a pop happens in the same cycle, the count used is done_q_count minus one.
- R4: An acknowledge write (ack_we) clears only the status bits that are set in both wr_data and 0xD6. Bits 0x01, 0x08 and 0x20 are never cleared by an acknowledge.
- R5: done_pop is high in the same cycle as an acknowledge write that has wr_data bit 1 set while done_q_count is non-zero. It is low at all other times.
- R6: When rx_pop is high, status bit 0x01 (receive) becomes 1 if rx_q_count is greater than one and 0 otherwise. Between pops, the bit is set by evt_set[0].
- R7: A high evt_set[k] sets status bit k on the next clock. It overrides a clear of that bit in the same cycle, whether from an acknowledge or from alloc_start. Bit 0x10 is receive overrun and bit 0x08 is allocation complete.
- R8: alloc_start clears status bit 0x08 on the next clock.
- R9: mask_we loads wr_data into the mask on the next clock. irq is high exactly when the registered status AND the registered mask is non-zero.
- R10: ack_we and mask_we may be high in the same cycle. Both then take effect from the one wr_data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_we | input | 1 | Acknowledge write strobe |
| mask_we | input | 1 | Mask write strobe |
| wr_data | input | 8 | Write value for acknowledge and mask |
| evt_set | input | 8 | One-cycle event pulses, one per status bit |
| alloc_start | input | 1 | New allocation request; clears bit 0x08 |
| rx_pop | input | 1 | Receive queue is popped this cycle |
| rx_q_count | input | 4 | Receive queue length before the pop |
| tx_q_count | input | 4 | Transmit queue length |
| done_q_count | input | 4 | Completion queue length |
| done_pop | output | 1 | Pop request to the completion queue |
| status | output | 8 | Interrupt status register |
| mask | output | 8 | Interrupt mask register |
| irq | output | 1 | Level interrupt output |

## Verification
Two updates can reach the same bit in one cycle. An acknowledge clear can meet a new event pulse on that bit, and an acknowledge of transmit-done can coincide with a completion queue that still holds entries. The bench drives both collisions on purpose: ack 0x10 together with an overrun pulse, and ack 0x02 with counts of 2, 1 and 0. A random phase then produces further collisions of ack, alloc_start, rx_pop and events. A behavioural model applies the clear first, then the sets, then the forced bits (using the post-pop count), and every clock its result is compared with status, irq and done_pop.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned RX_BIT    = 0;
  localparam int unsigned TXD_BIT   = 1;
  localparam int unsigned TXE_BIT   = 2;
  localparam int unsigned ALLOC_BIT = 3;
  localparam int unsigned OVRN_BIT  = 4;
  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [7:0] STATUS_RESET  = 8'h04;

  typedef enum logic [1:0] {
    BK_LATCH  = 2'd0,
    BK_FORCED = 2'd1,
    BK_LOADED = 2'd2
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input int unsigned idx);
    if (idx == TXE_BIT || idx == TXD_BIT) return BK_FORCED;
    if (idx == RX_BIT) return BK_LOADED;
    return BK_LATCH;
  endfunction
endpackage

// File: rtl/isc_rst_sync.sv
module isc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/isc_ack_decode.sv
module isc_ack_decode #(
  parameter int unsigned STAT_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter logic [STAT_W-1:0] CLR_MASK = STAT_W'(8'hD6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_we,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  done_q_count,
  output logic [STAT_W-1:0] ack_clr,
  output logic              done_pop
);
  import isc_pkg::*;
  logic txd_acked, queue_has;

  always_comb begin
    ack_clr   = ack_we ? (wr_data & CLR_MASK) : '0;
    txd_acked = ack_clr[TXD_BIT];
    queue_has = (done_q_count != '0);
    done_pop  = txd_acked & queue_has;
  end

  // R5: a pop request never comes without a transmit-done acknowledge
  a_r5_pop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |-> (ack_we && wr_data[TXD_BIT]));
endmodule

// File: rtl/isc_derive.sv
module isc_derive #(
  parameter int unsigned STAT_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic [CNT_W-1:0]  tx_q_count,
  input  logic [CNT_W-1:0]  done_q_count,
  input  logic              done_pop,
  input  logic [CNT_W-1:0]  rx_q_count,
  input  logic              rx_pop,
  input  logic              alloc_start,
  output logic [STAT_W-1:0] force_vec,
  output logic [STAT_W-1:0] side_clr,
  output logic [STAT_W-1:0] load_en,
  output logic [STAT_W-1:0] load_val
);
  import isc_pkg::*;
  logic [CNT_W-1:0] done_left;

  always_comb begin
    done_left = done_pop ? (done_q_count - CNT_W'(1)) : done_q_count;
    force_vec = '0;
    side_clr  = '0;
    load_en   = '0;
    load_val  = '0;
    force_vec[TXE_BIT]  = (tx_q_count == '0);
    force_vec[TXD_BIT]  = (done_left != '0);
    side_clr[ALLOC_BIT] = alloc_start;
    load_en[RX_BIT]     = rx_pop;
    load_val[RX_BIT]    = (rx_q_count > CNT_W'(1));
  end
endmodule

// File: rtl/isc_status_reg.sv
module isc_status_reg #(
  parameter int unsigned STAT_W = 8,
  parameter logic [STAT_W-1:0] RST_VAL = STAT_W'(8'h04)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] force_vec,
  input  logic [STAT_W-1:0] load_en,
  input  logic [STAT_W-1:0] load_val,
  output logic [STAT_W-1:0] status_q
);
  import isc_pkg::*;
  logic [STAT_W-1:0] status_d;
  logic              upd_en;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    localparam bit_kind_e KIND = kind_of(i);
    if (KIND == BK_FORCED) begin : g_forced
      always_comb status_d[i] = force_vec[i] | set_vec[i] | (status_q[i] & ~clr_vec[i]);
    end else if (KIND == BK_LOADED) begin : g_loaded
      always_comb status_d[i] = set_vec[i] |
        (load_en[i] ? load_val[i] : (status_q[i] & ~clr_vec[i]));
    end else begin : g_latch
      always_comb status_d[i] = set_vec[i] | (status_q[i] & ~clr_vec[i]);
    end

    // R7: an event pulse always lands in its bit
    a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status_q[i]);
  end

  always_comb upd_en = (status_d != status_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= RST_VAL;
    else if (upd_en) status_q <= status_d;
  end
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] mask_q
);
  logic [STAT_W-1:0] mask_d;

  always_comb mask_d = mask_we ? wr_data : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  // R9: a mask write is visible on the next clock
  a_r9_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wr_data)));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned STAT_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_we,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              alloc_start,
  input  logic              rx_pop,
  input  logic [CNT_W-1:0]  rx_q_count,
  input  logic [CNT_W-1:0]  tx_q_count,
  input  logic [CNT_W-1:0]  done_q_count,
  output logic              done_pop,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  import isc_pkg::*;
  localparam logic [STAT_W-1:0] CLR_MASK = STAT_W'(ACK_CLEARABLE);
  localparam logic [STAT_W-1:0] RST_VAL  = STAT_W'(STATUS_RESET);

  logic              rst_n_s;
  logic [STAT_W-1:0] ack_clr, side_clr, clr_all;
  logic [STAT_W-1:0] force_vec, load_en, load_val;

  isc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  isc_ack_decode #(.STAT_W(STAT_W), .CNT_W(CNT_W), .CLR_MASK(CLR_MASK)) u_ack (
    .clk(clk), .rst_n(rst_n_s), .ack_we(ack_we), .wr_data(wr_data),
    .done_q_count(done_q_count), .ack_clr(ack_clr), .done_pop(done_pop));

  isc_derive #(.STAT_W(STAT_W), .CNT_W(CNT_W)) u_der (
    .tx_q_count(tx_q_count), .done_q_count(done_q_count), .done_pop(done_pop),
    .rx_q_count(rx_q_count), .rx_pop(rx_pop), .alloc_start(alloc_start),
    .force_vec(force_vec), .side_clr(side_clr), .load_en(load_en),
    .load_val(load_val));

  always_comb clr_all = ack_clr | side_clr;

  isc_status_reg #(.STAT_W(STAT_W), .RST_VAL(RST_VAL)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .clr_vec(clr_all), .set_vec(evt_set),
    .force_vec(force_vec), .load_en(load_en), .load_val(load_val),
    .status_q(status));

  isc_mask_reg #(.STAT_W(STAT_W)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .mask_we(mask_we), .wr_data(wr_data),
    .mask_q(mask));

  always_comb irq = |(status & mask);

  // R2: an empty transmit queue keeps its bit set
  a_r2_txe_forced: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_q_count == '0) |=> status[TXE_BIT]);
  // R3: more than one completion entry keeps transmit-done set even across a pop
  a_r3_txd_forced: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_q_count > CNT_W'(1)) |=> status[TXD_BIT]);
  // R4: the receive bit ignores acknowledges
  a_r4_rx_not_acked: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ack_we && !rx_pop && !evt_set[RX_BIT]) |=> (status[RX_BIT] == $past(status[RX_BIT])));
  // R6: popping the last receive entry clears the receive bit
  a_r6_rx_drain: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_pop && rx_q_count <= CNT_W'(1) && !evt_set[RX_BIT]) |=> !status[RX_BIT]);
  // R8: an allocation request drops the allocation-complete bit
  a_r8_alloc_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alloc_start && !evt_set[ALLOC_BIT]) |=> !status[ALLOC_BIT]);
  // R9: a zero mask silences the interrupt
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mask == '0) |-> !irq);
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_we = 1'b0, mask_we = 1'b0, alloc_start = 1'b0, rx_pop = 1'b0;
  logic [7:0] wr_data = '0, evt_set = '0;
  logic [3:0] rx_q_count = '0, tx_q_count = '0, done_q_count = '0;
  logic done_pop, irq;
  logic [7:0] status, mask;

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;
  string cur_req = "R1";
  int m_st = 8'h04, m_mk = 0, nxt = 0;

  always #4 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ack_we(ack_we), .mask_we(mask_we),
    .wr_data(wr_data), .evt_set(evt_set), .alloc_start(alloc_start),
    .rx_pop(rx_pop), .rx_q_count(rx_q_count), .tx_q_count(tx_q_count),
    .done_q_count(done_q_count), .done_pop(done_pop), .status(status),
    .mask(mask), .irq(irq));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one clock: check combinational pop, advance model, compare registers
  task automatic step();
    int exp_pop, dleft;
    #1;
    exp_pop = (ack_we && wr_data[1] && done_q_count != 0) ? 1 : 0;
    check(cur_req, "done_pop", int'(done_pop), exp_pop);
    nxt = m_st;
    if (ack_we) nxt = nxt & ~(int'(wr_data) & 8'hD6);
    if (alloc_start) nxt = nxt & ~8'h08;
    if (rx_pop) nxt = (nxt & ~1) | ((rx_q_count > 1) ? 1 : 0);
    nxt = nxt | int'(evt_set);
    if (tx_q_count == 0) nxt = nxt | 8'h04;
    dleft = int'(done_q_count) - exp_pop;
    if (dleft != 0) nxt = nxt | 8'h02;
    @(posedge clk);
    m_st = nxt;
    if (mask_we) m_mk = int'(wr_data);
    @(negedge clk);
    check(cur_req, "status", int'(status), m_st);
    check(cur_req, "mask", int'(mask), m_mk);
    check(cur_req, "irq", int'(irq), ((m_st & m_mk) != 0) ? 1 : 0);
    ack_we = 0; mask_we = 0; alloc_start = 0; rx_pop = 0; evt_set = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    #10;
    // R1: reset values while reset is held
    check("R1", "status in reset", int'(status), 8'h04);
    check("R1", "mask in reset", int'(mask), 0);
    check("R1", "irq in reset", int'(irq), 0);
    check("R1", "done_pop in reset", int'(done_pop), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    cur_req = "R1"; step();

    // R2: sticky transmit-empty, re-forced while the queue is empty
    cur_req = "R2";
    tx_q_count = 3; step();
    ack_we = 1; wr_data = 8'h04; step();
    tx_q_count = 0; step();
    ack_we = 1; wr_data = 8'h04; step();
    tx_q_count = 2;

    // R3 and R5: completion queue and pop on acknowledge
    cur_req = "R3"; done_q_count = 2; step(); step();
    cur_req = "R5";
    ack_we = 1; wr_data = 8'h02; step();
    done_q_count = 1; ack_we = 1; wr_data = 8'h02; step();
    done_q_count = 0; ack_we = 1; wr_data = 8'h02; step();
    ack_we = 1; wr_data = 8'hFD; done_q_count = 3; step();
    done_q_count = 0; ack_we = 1; wr_data = 8'h02; step();

    // R4: only clearable bits respond to an acknowledge
    cur_req = "R4";
    evt_set = 8'hFF; step();
    ack_we = 1; wr_data = 8'hFF; step();

    // R7: set beats a same-cycle clear
    cur_req = "R7";
    evt_set = 8'h10; ack_we = 1; wr_data = 8'h10; step();
    evt_set = 8'h08; alloc_start = 1; step();

    // R8: allocation request clears allocation complete
    cur_req = "R8"; alloc_start = 1; step();

    // R6: receive bit after a pop
    cur_req = "R6";
    rx_pop = 1; rx_q_count = 2; step();
    rx_pop = 1; rx_q_count = 1; step();
    evt_set = 8'h01; rx_q_count = 0; step();
    rx_pop = 1; step();

    // R9: mask and interrupt line
    cur_req = "R9";
    mask_we = 1; wr_data = 8'h10; step();
    evt_set = 8'h10; step();
    ack_we = 1; wr_data = 8'h10; step();
    mask_we = 1; wr_data = 8'h00; step();
    evt_set = 8'h20; step();

    // R10: acknowledge and mask write in one cycle
    cur_req = "R10";
    done_q_count = 1; step();
    ack_we = 1; mask_we = 1; wr_data = 8'h02; step();
    done_q_count = 0; step();

    // mixed traffic: collisions of every kind
    cur_req = "R7";
    for (int n = 0; n < 600; n++) begin
      tx_q_count   = 4'($urandom_range(0, 3));
      done_q_count = 4'($urandom_range(0, 3));
      rx_q_count   = 4'($urandom_range(0, 3));
      wr_data      = 8'($urandom);
      ack_we       = ($urandom_range(0, 3) == 0);
      mask_we      = ($urandom_range(0, 9) == 0);
      rx_pop       = ($urandom_range(0, 4) == 0);
      alloc_start  = ($urandom_range(0, 9) == 0);
      evt_set      = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      step();
    end
    finish_run();
  end
endmodule